// File: doc/BRIEF.md
# Save-RAM Chip-Enable and Write-Enable Gate

This block drives the single active-low chip enable and the write enable of a battery-backed work RAM that sits behind a serially loaded bank-switching mapper. It contains the mapper's 5-bit serial load path and its four 5-bit registers (control, two character-bank registers and a program-bank register). From the enable bits those registers hold, it derives whether the RAM may be selected for a CPU access to the 0x6000–0x7FFF window while the bus phase clock M2 is high.

Two choices guard saved data against corruption while power is unstable. First, the RAM write enable is forced inactive whenever the chip enable is inactive, rather than wiring the CPU read/write line straight to the RAM. Second, the program-bank disable bit only acts from power-on until the first serial-reset write (a register-space write with data bit 7 set). Software that never expects that bit to exist therefore still reaches its RAM, while the RAM stays protected during power-up. Both character-bank disable bits also gate the same single chip enable, and the power-on character mode is a parameter so that both can protect the RAM from the start.

Top module: `wram_gate_top`

## Requirements
- R1: `ram_we_n` is 1 in every cycle in which `ram_ce_n` is 1.
- R2: While `ram_ce_n` is 0, `ram_we_n` equals `cpu_rw` (1 = read, 0 = write).
- R3: `ram_ce_n` is 0 only while `m2` is 1, `cpu_addr[15:13]` is 3'b011 (0x6000–0x7FFF) and no enable bit blocks the RAM.
- R4: Bit 4 of the program-bank register (1 = disabled) blocks the RAM until the first register-space write with `cpu_data[7]` = 1. From then on it has no effect until the next reset.
- R5: A register-space write with `cpu_data[7]` = 1 discards any partly shifted value, so the next five writes form a complete new value. It also forces control bits 3:2 to 2'b11.
- R6: A CPU write (`cpu_rw` = 0, latched on the rising edge of `m2`) to 0x8000–0xFFFF shifts `cpu_data[0]` in LSB first. The fifth such write loads the 5-bit value into the register chosen by `cpu_addr[14:13]`: 0 control, 1 char bank 0, 2 char bank 1, 3 program bank.
- R7: Bit 4 of char bank 0 (1 = disabled) blocks the RAM in both character modes.
- R8: Bit 4 of char bank 1 (1 = disabled) blocks the RAM only when control bit 4 is 1 (4 KB character mode). With control bit 4 = 0 (8 KB mode) it has no effect.
- R9: Reset clears all registers, the shift state and the retirement flag, sets program-bank bit 4 (RAM blocked) and loads control bit 4 from parameter `INIT_CHR_4K`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst | input | 1 | Synchronous active-high power-on reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_rw | input | 1 | CPU read/write, 1 = read |
| m2 | input | 1 | CPU bus phase clock, high during the data phase |
| ram_ce_n | output | 1 | Work RAM chip enable, active low |
| ram_we_n | output | 1 | Work RAM write enable, active low |

## Verification
Directed sequences test the program-bank disable bit both before and after a serial-reset write, which separates a retired bit from one that is still active or was never honoured. They also load char bank 1 in both character modes to show the mode selects which enable bits count. Another sequence interrupts a partial serial load with a reset write, so a design that keeps stale shift bits commits a wrong value and leaves the RAM open. A seeded random mix of RAM-window, register-space and unrelated accesses, with occasional reset writes and both read and write directions, is compared cycle by cycle against a bench model. That comparison catches mistakes in the address window, the M2 qualification and the /WE gating.

// File: rtl/wram_pkg.sv
package wram_pkg;

    localparam int REG_W        = 5;
    localparam int DIS_BIT      = 4;   // enable bit in each bank register
    localparam int CHR_MODE_BIT = 4;   // control: 1 = 4 KB character mode
    localparam int PRG_MODE_HI  = 3;
    localparam int PRG_MODE_LO  = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CHR0 = 2'd1,
        SEL_CHR1 = 2'd2,
        SEL_PRG  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] chr0;
        logic [REG_W-1:0] chr1;
        logic [REG_W-1:0] prg;
        logic             retired;
    } bank_state_t;

    function automatic logic in_ram_window(input logic [15:0] a);
        return a[15:13] == 3'b011;
    endfunction

    function automatic logic ram_blocked(input bank_state_t s);
        logic chr_block;
        logic prg_block;
        chr_block = s.chr0[DIS_BIT] | (s.ctrl[CHR_MODE_BIT] & s.chr1[DIS_BIT]);
        prg_block = ~s.retired & s.prg[DIS_BIT];
        return chr_block | prg_block;
    endfunction

endpackage

// File: rtl/wram_serial_loader.sv
module wram_serial_loader
    import wram_pkg::*;
#(
    parameter int SHIFT_W = REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_evt,
    input  logic [7:0]         din,
    input  logic [1:0]         sel_in,
    output logic               commit,
    output reg_sel_e           commit_sel,
    output logic [SHIFT_W-1:0] commit_val,
    output logic               serial_reset
);
    localparam int CNT_W = $clog2(SHIFT_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_W - 1);

    logic [SHIFT_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic [SHIFT_W-1:0] next_val;

    assign next_val     = {din[0], shreg[SHIFT_W-1:1]};
    assign serial_reset = wr_evt & din[7];
    assign commit       = wr_evt & ~din[7] & (cnt == LAST);
    assign commit_sel   = reg_sel_e'(sel_in);
    assign commit_val   = next_val;

    always_ff @(posedge clk) begin
        if (rst || serial_reset || commit) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (wr_evt) begin
            shreg <= next_val;
            cnt   <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(SHIFT_W));
    p_commit_restart_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt == '0));
    p_reset_discard_r5: assert property (@(posedge clk) disable iff (rst)
        serial_reset |=> (cnt == '0) && (shreg == '0));

endmodule

// File: rtl/wram_bank_regs.sv
module wram_bank_regs
    import wram_pkg::*;
#(
    parameter bit INIT_CHR_4K = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  reg_sel_e         commit_sel,
    input  logic [REG_W-1:0] commit_val,
    input  logic             serial_reset,
    output bank_state_t      state
);
    bank_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q                    <= '0;
            st_q.ctrl[CHR_MODE_BIT] <= INIT_CHR_4K;
            st_q.prg[DIS_BIT]       <= 1'b1;
        end else if (serial_reset) begin
            st_q.ctrl[PRG_MODE_HI:PRG_MODE_LO] <= 2'b11;
            st_q.retired                       <= 1'b1;
        end else if (commit) begin
            unique case (commit_sel)
                SEL_CTRL: st_q.ctrl <= commit_val;
                SEL_CHR0: st_q.chr0 <= commit_val;
                SEL_CHR1: st_q.chr1 <= commit_val;
                SEL_PRG:  st_q.prg  <= commit_val;
                default:  ;
            endcase
        end
    end

    assign state = st_q;

    p_retire_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.retired |=> st_q.retired);
    p_mode_forced_r5: assert property (@(posedge clk) disable iff (rst)
        serial_reset |=> (st_q.ctrl[PRG_MODE_HI:PRG_MODE_LO] == 2'b11) && st_q.retired);
    p_retire_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.retired) |-> $past(serial_reset));

endmodule

// File: rtl/wram_ram_gate.sv
module wram_ram_gate
    import wram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        m2,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    input  bank_state_t state,
    output logic        ram_ce_n,
    output logic        ram_we_n
);
    logic select;

    always_comb begin
        select   = m2 & in_ram_window(cpu_addr) & ~ram_blocked(state);
        ram_ce_n = ~select;
        ram_we_n = ram_ce_n | cpu_rw;
    end

    p_we_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ram_ce_n |-> ram_we_n);
    p_we_follows_r2: assert property (@(posedge clk) disable iff (rst)
        !ram_ce_n |-> (ram_we_n == cpu_rw));
    p_ce_window_r3: assert property (@(posedge clk) disable iff (rst)
        !ram_ce_n |-> (m2 && cpu_addr[15:13] == 3'b011));
    p_chr0_block_r7: assert property (@(posedge clk) disable iff (rst)
        state.chr0[DIS_BIT] |-> ram_ce_n);

endmodule

// File: rtl/wram_gate_top.sv
module wram_gate_top
    import wram_pkg::*;
#(
    parameter bit INIT_CHR_4K = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_rw,
    input  logic        m2,
    output logic        ram_ce_n,
    output logic        ram_we_n
);
    logic             m2_q;
    logic             wr_evt;
    logic             commit;
    reg_sel_e         commit_sel;
    logic [REG_W-1:0] commit_val;
    logic             serial_reset;
    bank_state_t      state;

    always_ff @(posedge clk) begin
        if (rst) m2_q <= 1'b0;
        else     m2_q <= m2;
    end

    assign wr_evt = m2 & ~m2_q & ~cpu_rw & cpu_addr[15];

    wram_serial_loader #(.SHIFT_W(REG_W)) u_loader (
        .clk          (clk),
        .rst          (rst),
        .wr_evt       (wr_evt),
        .din          (cpu_data),
        .sel_in       (cpu_addr[14:13]),
        .commit       (commit),
        .commit_sel   (commit_sel),
        .commit_val   (commit_val),
        .serial_reset (serial_reset)
    );

    wram_bank_regs #(.INIT_CHR_4K(INIT_CHR_4K)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .commit_sel   (commit_sel),
        .commit_val   (commit_val),
        .serial_reset (serial_reset),
        .state        (state)
    );

    wram_ram_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .m2       (m2),
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .state    (state),
        .ram_ce_n (ram_ce_n),
        .ram_we_n (ram_we_n)
    );

endmodule

// File: tb/tb_wram_gate_top.sv
module tb_wram_gate_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        m2 = 1'b0;
    logic        ram_ce_n;
    logic        ram_we_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // bench model of the register state
    logic [4:0] m_ctrl, m_chr0, m_chr1, m_prg, m_sh;
    int         m_cnt;
    bit         m_ret;

    always #10 clk = ~clk;   // 50 MHz

    wram_gate_top #(.INIT_CHR_4K(1'b1)) dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .m2(m2), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog (all R): actual=hung expected=finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual ce_n/we_n=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [1:0] expect_out(input logic [15:0] a, input logic rw,
                                              input logic ph);
        logic blk, sel;
        blk = m_chr0[4] | (m_ctrl[4] & m_chr1[4]) | (!m_ret & m_prg[4]);
        sel = ph && (a[15:13] == 3'b011) && !blk;
        return {!sel, !sel | rw};
    endfunction

    task automatic model_reset();
        m_ctrl = 5'b10000; m_chr0 = '0; m_chr1 = '0; m_prg = 5'b10000;
        m_sh = '0; m_cnt = 0; m_ret = 1'b0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (!a[15]) return;
        if (d[7]) begin
            m_sh = '0; m_cnt = 0; m_ret = 1'b1; m_ctrl[3:2] = 2'b11;
        end else begin
            m_sh = {d[0], m_sh[4:1]};
            m_cnt++;
            if (m_cnt == 5) begin
                case (a[14:13])
                    2'd0: m_ctrl = m_sh;
                    2'd1: m_chr0 = m_sh;
                    2'd2: m_chr1 = m_sh;
                    default: m_prg = m_sh;
                endcase
                m_sh = '0; m_cnt = 0;
            end
        end
    endtask

    // one bus cycle; outputs sampled during and after the M2-high phase
    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw,
                       input string req);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; m2 = 1'b1;
        if (!rw) model_write(a, d);
        @(negedge clk);
        chk(req, {ram_ce_n, ram_we_n}, expect_out(a, rw, 1'b1));
        m2 = 1'b0;
        @(negedge clk);
        chk({req, " m2-low"}, {ram_ce_n, ram_we_n}, expect_out(a, rw, 1'b0));
    endtask

    task automatic load(input logic [15:0] a, input logic [4:0] v, input string req);
        for (int i = 0; i < 5; i++) bus(a, {7'd0, v[i]}, 1'b0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; m2 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        void'($urandom(32'h5A17));
        model_reset();
        do_reset();

        // R9/R4: RAM blocked straight after reset
        bus(16'h6000, 8'h00, 1'b1, "R9 reset blocks");
        chk("R9 reset ce", {ram_ce_n, ram_we_n}, 2'b11);

        // R6/R4: clear program-bank disable through serial load
        load(16'hE000, 5'h00, "R6 load prg");
        bus(16'h6123, 8'h00, 1'b1, "R2 read");
        chk("R2 read we high", {ram_ce_n, ram_we_n}, 2'b11); // M2 low now
        bus(16'h7FFF, 8'h55, 1'b0, "R2 write");
        // R3: window edges
        bus(16'h5FFF, 8'h00, 1'b1, "R3 below window");
        bus(16'h8000, 8'h80, 1'b1, "R3 above window");
        // R4: set disable again before retirement
        load(16'hE000, 5'h10, "R4 prg set");
        bus(16'h6000, 8'h00, 1'b0, "R4 blocked pre-retire");
        bus(16'h6000, 8'h00, 1'b0, "R1 we idle while blocked");
        // R4: retirement write, bit now ignored
        bus(16'h8000, 8'h80, 1'b0, "R4 retire write");
        bus(16'h6000, 8'h00, 1'b1, "R4 open after retire");
        bus(16'h6000, 8'h00, 1'b0, "R4 write after retire");
        load(16'hE000, 5'h10, "R4 prg set after retire");
        bus(16'h6010, 8'h00, 1'b1, "R4 still ignored");

        // R5: partial load discarded by reset write, then char bank 0 disable
        bus(16'hA000, 8'h01, 1'b0, "R5 partial");
        bus(16'hA000, 8'h01, 1'b0, "R5 partial");
        bus(16'hA000, 8'h01, 1'b0, "R5 partial");
        bus(16'hA000, 8'hFF, 1'b0, "R5 reset write");
        load(16'hA000, 5'h10, "R5 fresh load");
        bus(16'h6000, 8'h00, 1'b1, "R5/R7 chr0 blocks");
        chk("R7 chr0 blocks", {ram_ce_n, ram_we_n}, 2'b11);
        load(16'h8000, 5'h00, "R7 8KB mode");
        bus(16'h6000, 8'h00, 1'b0, "R7 chr0 blocks in 8KB");

        // R8: char bank 1 counts only in 4 KB mode
        load(16'hA000, 5'h00, "R8 clear chr0");
        load(16'hC000, 5'h10, "R8 set chr1");
        bus(16'h6000, 8'h00, 1'b1, "R8 8KB chr1 ignored");
        load(16'h8000, 5'h10, "R8 4KB mode");
        bus(16'h6000, 8'h00, 1'b1, "R8 4KB chr1 blocks");
        load(16'hC000, 5'h00, "R8 clear chr1");
        bus(16'h6000, 8'h00, 1'b0, "R8 4KB open");

        // random mix against the model (R1 R2 R3 R6)
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          k;
            k = int'($urandom % 4);
            case (k)
                0: a = 16'h6000 | 16'($urandom % 16'h2000);
                1: a = 16'h8000 | 16'($urandom % 16'h8000);
                2: a = 16'($urandom);
                default: a = 16'h6000;
            endcase
            d = 8'($urandom) & 8'h7F;
            if ($urandom % 12 == 0) d[7] = 1'b1;
            bus(a, d, 1'($urandom), "R1/R2/R3/R6 random");
        end

        // R9: a new reset brings the disable bit back into force
        do_reset();
        bus(16'h6000, 8'h00, 1'b1, "R9 reset re-arms");
        load(16'hE000, 5'h10, "R9 prg set");
        bus(16'h6000, 8'h00, 1'b0, "R9 blocked again");

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule